// File: doc/BRIEF.md
# Prefetching Stream Buffer

This block is a small queue of wide stream elements. It sits between a compute cluster that reads and writes whole elements and a narrow external memory port. The consumer removes the oldest element with pop. It can also look at any buffered element with peek, which takes an offset counted from the oldest element and removes nothing.

The buffer has two fill sources, and a mode input picks one. In memory mode, a prefetch engine is started with a base word address and an element count. It then requests narrow words one address at a time and packs every four responses into one wide element. It keeps issuing requests whenever space can be set aside, so a consumer that keeps up never waits. In link mode, an upstream accelerator writes whole elements with push, and the block serves as the buffer between two accelerators.

The engine sets space aside at the moment it issues the first word request of an element. Responses still in flight can therefore never find the buffer full.

Top module: `stream_unit`

## Requirements
- R1: In link mode (`mode_link`=1), a push accepted while the buffer holds fewer than DEPTH (8) elements appends `push_data` at the tail, and `level` rises by one on the next cycle.
- R2: While `level` is non-zero, `pop_data` shows the oldest element. A pop accepted at a clock edge removes that element and lowers `level` by one.
- R3: `peek_valid` is 1 exactly when `peek_off` < `level`. In that case `peek_data` is the element `peek_off` places after the oldest one (offset 0 is the head). Peek changes no state.
- R4: When `level` is 0, `pop_req` raises `pop_stall` and `peek_req` raises `peek_stall` in the same cycle. Neither changes `level` or the contents.
- R5: In link mode, a push while `level` is DEPTH raises `push_busy` in the same cycle. The element is not stored and no stored element is lost.
- R6: A push and a pop accepted in the same cycle both take effect. `level` stays the same, and the pushed element lands behind the remaining ones.
- R7: In memory mode, a `start` pulse loads `base_addr` and `elem_count`. The engine then issues exactly `elem_count`×4 requests, at addresses `base_addr`, `base_addr`+1, and so on in steps of one (modulo 2^16). Requests go out only while `mode_link` is 0.
- R8: Four consecutive responses form one element in little-endian order: the first response goes to bits 15:0 and the fourth to bits 63:48. Elements leave in request order.
- R9: The engine issues the first word of an element only while `level` plus the elements already requested stays below DEPTH. With an idle consumer and a prompt memory, it fills the buffer to DEPTH and stops after exactly DEPTH×4 requests.
- R10: After a start, `done` is 1 exactly when all `elem_count` elements have been delivered and the buffer is empty. While `done` is 1, no request is issued.
- R11: In memory mode, `push_valid` is ignored: `level` does not change and `push_busy` stays 0.
- R12: A request not accepted (`mem_req_ready`=0) is held on the next cycle with the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_link | input | 1 | 0: memory fill by prefetch, 1: fill by push |
| start | input | 1 | Pulse that starts a prefetch run (memory mode) |
| base_addr | input | 16 | First narrow word address of the run |
| elem_count | input | 8 | Number of wide elements in the run |
| push_valid | input | 1 | Upstream element offered (link mode) |
| push_data | input | 64 | Element offered by upstream |
| push_busy | output | 1 | Push refused because the buffer is full |
| pop_req | input | 1 | Remove the oldest element |
| pop_data | output | 64 | Oldest element |
| pop_stall | output | 1 | Pop requested on an empty buffer |
| peek_req | input | 1 | Peek requested (used only for the stall flag) |
| peek_off | input | 3 | Peek offset from the oldest element |
| peek_data | output | 64 | Element at the peek offset |
| peek_valid | output | 1 | Offset lies inside the occupied range |
| peek_stall | output | 1 | Peek requested on an empty buffer |
| level | output | 4 | Number of elements held |
| mem_req_valid | output | 1 | Word request to external memory |
| mem_req_addr | output | 16 | Word address of the request |
| mem_req_ready | input | 1 | External memory accepts the request |
| mem_rsp_valid | input | 1 | Response word present, in request order |
| mem_rsp_data | input | 16 | Response word |
| done | output | 1 | Run fully delivered and drained |

## Verification
In link mode the buffer is driven in three stretches. A push-heavy stretch pins it at full and separates refusal (R5) from silent loss. A pop-heavy stretch holds it at empty and exposes the stall flags. A balanced stretch brings many same-cycle push-and-pop pairs (R6). Random peek offsets in all three stretches compare `peek_valid` and `peek_data` against a queue model, which catches off-by-one bounds and wrong pointer arithmetic. In memory mode, the bench first leaves the consumer idle under a prompt memory to measure the reservation limit (R9). It then mixes random ready, random response delay and random pops to check word order, lane packing, address stepping and the exact cycle when `done` rises.

// File: rtl/stream_pkg.sv
// Shared type for the stream buffer: which source fills the element store.
package stream_pkg;
    typedef enum logic {
        SRC_MEMORY = 1'b0,
        SRC_LINK   = 1'b1
    } fill_src_e;
endpackage

// File: rtl/stream_store.sv
// Circular store of wide elements with separate head and tail pointers.
// Gives the head element and one element at an offset from the head.
// Assumes: DEPTH is a power of two; the caller writes only when not full
// and reads only when not empty.
module stream_store #(
    parameter int W     = 64,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_en,
    input  logic [PTR_W-1:0] peek_off,
    output logic [W-1:0]     head_data,
    output logic [W-1:0]     peek_data,
    output logic             peek_ok,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr, peek_idx;
    logic [LVL_W-1:0] cnt;

    // Element write at the tail.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy update; write and read may coincide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + LVL_W'(wr_en) - LVL_W'(rd_en);
        end
    end

    // Head and offset views.
    always_comb begin
        peek_idx  = rd_ptr + peek_off;
        head_data = mem_q[rd_ptr];
        peek_data = mem_q[peek_idx];
        peek_ok   = LVL_W'(peek_off) < cnt;
    end

    assign level = cnt;
    assign full  = (cnt == LVL_W'(DEPTH));
    assign empty = (cnt == '0);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
endmodule

// File: rtl/stream_packer.sv
// Packs RATIO narrow response words into one wide element, with the first
// word in the least significant lane. The element is offered in the cycle
// of its last word.
// Assumes: RATIO is a power of two and at least 2; responses arrive in order.
module stream_packer #(
    parameter int NW    = 16,
    parameter int RATIO = 4,
    localparam int SLOT_W = $clog2(RATIO),
    localparam int WIDE_W = NW * RATIO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              rsp_valid,
    input  logic [NW-1:0]     rsp_data,
    output logic              elem_valid,
    output logic [WIDE_W-1:0] elem_data
);
    logic [SLOT_W-1:0] slot;

    // Lane position of the next response word.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) slot <= '0;
        else if (rsp_valid)  slot <= slot + 1'b1;
    end

    // Holding registers for all lanes except the last.
    for (genvar g = 0; g < RATIO - 1; g++) begin : g_lane
        logic [NW-1:0] lane_q;
        // Capture the word that belongs to lane g.
        always_ff @(posedge clk) begin
            if (rsp_valid && slot == SLOT_W'(g)) lane_q <= rsp_data;
        end
        assign elem_data[g*NW +: NW] = lane_q;
    end

    assign elem_data[(RATIO-1)*NW +: NW] = rsp_data;
    assign elem_valid = rsp_valid && (slot == SLOT_W'(RATIO - 1));

    // R8
    lane_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !clear) |=> (slot != $past(slot)));
endmodule

// File: rtl/stream_fetch.sv
// Prefetch address generator. On start it walks narrow word addresses from
// the base. It sets aside one store slot when it issues the first word of an
// element, so data in flight always has a place to land.
// Assumes: start comes with the store empty and no responses in flight;
// enable (memory mode) does not change during a run.
module stream_fetch #(
    parameter int AW    = 16,
    parameter int CW    = 8,
    parameter int RATIO = 4,
    parameter int DEPTH = 8,
    localparam int SLOT_W = $clog2(RATIO),
    localparam int WL_W   = CW + SLOT_W,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic [AW-1:0]    base,
    input  logic [CW-1:0]    count,
    input  logic             req_ready,
    input  logic [LVL_W-1:0] level,
    input  logic             elem_done,
    output logic             req_valid,
    output logic [AW-1:0]    req_addr,
    output logic [LVL_W-1:0] reserved,
    output logic             done
);
    logic              active;
    logic [AW-1:0]     addr;
    logic [WL_W-1:0]   words_left;
    logic [SLOT_W-1:0] slot;
    logic [LVL_W-1:0]  resv;
    logic [CW-1:0]     deliv_left;
    logic              room, fire;

    // Request gating: a new element needs a free store slot.
    always_comb begin
        room      = ((LVL_W+1)'(level) + (LVL_W+1)'(resv)) < (LVL_W+1)'(DEPTH);
        req_valid = enable && active && (words_left != '0) && ((slot != '0) || room);
        fire      = req_valid && req_ready;
    end

    // Run state: address walk, word budget, reservations, deliveries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            addr       <= '0;
            words_left <= '0;
            slot       <= '0;
            resv       <= '0;
            deliv_left <= '0;
        end else if (start && enable) begin
            active     <= 1'b1;
            addr       <= base;
            words_left <= {count, SLOT_W'(0)};
            slot       <= '0;
            resv       <= '0;
            deliv_left <= count;
        end else begin
            if (fire) begin
                addr       <= addr + 1'b1;
                words_left <= words_left - 1'b1;
                slot       <= slot + 1'b1;
            end
            resv <= resv + LVL_W'(fire && slot == '0) - LVL_W'(elem_done);
            if (elem_done) deliv_left <= deliv_left - 1'b1;
        end
    end

    assign req_addr = addr;
    assign reserved = resv;
    assign done     = active && (deliv_left == '0) && (level == '0);

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !start) |=> (req_valid && $stable(req_addr)));
    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);
endmodule

// File: rtl/stream_unit.sv
// Stream buffer between a compute cluster and a narrow memory port.
// The mode picks the fill source: the prefetch engine with its packer, or
// upstream pushes. Pop and peek serve the consumer in both modes.
// Assumes: mode_link changes only while no run is active.
module stream_unit #(
    parameter int NW    = 16,
    parameter int RATIO = 4,
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int CW    = 8,
    localparam int WIDE_W = NW * RATIO,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_link,
    input  logic              start,
    input  logic [AW-1:0]     base_addr,
    input  logic [CW-1:0]     elem_count,
    input  logic              push_valid,
    input  logic [WIDE_W-1:0] push_data,
    output logic              push_busy,
    input  logic              pop_req,
    output logic [WIDE_W-1:0] pop_data,
    output logic              pop_stall,
    input  logic              peek_req,
    input  logic [PTR_W-1:0]  peek_off,
    output logic [WIDE_W-1:0] peek_data,
    output logic              peek_valid,
    output logic              peek_stall,
    output logic [LVL_W-1:0]  level,
    output logic              mem_req_valid,
    output logic [AW-1:0]     mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [NW-1:0]     mem_rsp_data,
    output logic              done
);
    import stream_pkg::*;

    fill_src_e         src;
    logic              full, empty, wr_en, rd_en, pack_valid, mem_mode;
    logic [WIDE_W-1:0] pack_data, wr_data;
    logic [LVL_W-1:0]  reserved;

    // Source select and consumer handshake.
    always_comb begin
        src       = fill_src_e'(mode_link);
        mem_mode  = (src == SRC_MEMORY);
        push_busy = (src == SRC_LINK) && push_valid && full;
        wr_en     = (src == SRC_LINK) ? (push_valid && !full) : pack_valid;
        wr_data   = (src == SRC_LINK) ? push_data : pack_data;
        rd_en     = pop_req && !empty;
        pop_stall = pop_req && empty;
        peek_stall = peek_req && empty;
    end

    stream_store #(.W(WIDE_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .peek_off(peek_off), .head_data(pop_data),
        .peek_data(peek_data), .peek_ok(peek_valid), .level(level),
        .full(full), .empty(empty)
    );

    stream_packer #(.NW(NW), .RATIO(RATIO)) u_pack (
        .clk(clk), .rst_n(rst_n), .clear(start),
        .rsp_valid(mem_rsp_valid && mem_mode), .rsp_data(mem_rsp_data),
        .elem_valid(pack_valid), .elem_data(pack_data)
    );

    stream_fetch #(.AW(AW), .CW(CW), .RATIO(RATIO), .DEPTH(DEPTH)) u_fetch (
        .clk(clk), .rst_n(rst_n), .enable(mem_mode), .start(start),
        .base(base_addr), .count(elem_count), .req_ready(mem_req_ready),
        .level(level), .elem_done(pack_valid && mem_mode),
        .req_valid(mem_req_valid), .req_addr(mem_req_addr),
        .reserved(reserved), .done(done)
    );

    // R9
    reserve_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_mode |-> ((LVL_W+1)'(level) + (LVL_W+1)'(reserved)) <= (LVL_W+1)'(DEPTH));
    // R9
    packed_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pack_valid && mem_mode) |-> !full);
    // R4
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_stall && !wr_en) |=> (level == '0));
    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_busy && !rd_en) |=> (level == LVL_W'(DEPTH)));
endmodule

// File: tb/sim_stream_unit.sv
`timescale 1ns/1ps
module sim_stream_unit;
    localparam int DEPTH = 8;
    localparam int NREQ_RUN = 20;

    logic        clk = 1'b0;
    logic        rst_n, mode_link, start, push_valid, pop_req, peek_req;
    logic [15:0] base_addr;
    logic [7:0]  elem_count;
    logic [63:0] push_data, pop_data, peek_data;
    logic        push_busy, pop_stall, peek_valid, peek_stall, done;
    logic [2:0]  peek_off;
    logic [3:0]  level;
    logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [15:0] mem_req_addr, mem_rsp_data;

    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    stream_unit u0 (
        .clk(clk), .rst_n(rst_n), .mode_link(mode_link), .start(start),
        .base_addr(base_addr), .elem_count(elem_count),
        .push_valid(push_valid), .push_data(push_data), .push_busy(push_busy),
        .pop_req(pop_req), .pop_data(pop_data), .pop_stall(pop_stall),
        .peek_req(peek_req), .peek_off(peek_off), .peek_data(peek_data),
        .peek_valid(peek_valid), .peek_stall(peek_stall), .level(level),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done)
    );

    // Memory content model: word value at a narrow address.
    function automatic logic [15:0] word_at(input logic [15:0] a);
        return a * 16'd7 + 16'h1234;
    endfunction

    // Expected wide element k of a run: first word in the low lane (R8).
    function automatic logic [63:0] elem_at(input logic [15:0] b, input int k);
        logic [15:0] a;
        a = b + 16'(4 * k);
        return {word_at(a + 16'd3), word_at(a + 16'd2), word_at(a + 16'd1), word_at(a)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        start = 0; push_valid = 0; pop_req = 0; peek_req = 0; peek_off = 0;
        push_data = '0; mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
    endtask

    task automatic do_reset(input logic link);
        @(negedge clk);
        rst_n = 0; mode_link = link; idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    // Link mode random stretch against a queue model.
    logic [63:0] wq[$];
    bit both_prev = 0;

    task automatic link_stretch(input int cycles, input int pp, input int pr);
        for (int i = 0; i < cycles; i++) begin
            int sz;
            bit pa, qa;
            @(negedge clk);
            push_valid = ($urandom % 100) < pp;
            push_data  = {$urandom, $urandom};
            pop_req    = ($urandom % 100) < pr;
            peek_req   = $urandom % 2;
            peek_off   = 3'($urandom % 8);
            #1;
            sz = wq.size();
            chk(level == 4'(sz), both_prev ? "R6" : "R1", 64'(level), 64'(sz));
            chk(push_busy == (push_valid && sz == DEPTH), "R5", 64'(push_busy), 64'(push_valid && sz == DEPTH));
            chk(pop_stall == (pop_req && sz == 0), "R4", 64'(pop_stall), 64'(pop_req && sz == 0));
            chk(peek_stall == (peek_req && sz == 0), "R4", 64'(peek_stall), 64'(peek_req && sz == 0));
            chk(peek_valid == (int'(peek_off) < sz), "R3", 64'(peek_valid), 64'(int'(peek_off) < sz));
            if (sz > 0) chk(pop_data == wq[0], "R2", pop_data, wq[0]);
            if (int'(peek_off) < sz) chk(peek_data == wq[peek_off], "R3", peek_data, wq[peek_off]);
            pa = push_valid && sz < DEPTH;
            qa = pop_req && sz > 0;
            both_prev = pa && qa;
            if (qa) void'(wq.pop_front());
            if (pa) wq.push_back(push_data);
        end
    endtask

    // Memory model state.
    logic [15:0] paddr[$];
    int          pcyc[$];
    int cyc = 0, nreq = 0, rsp_done = 0, popped = 0;
    bit drove_rsp = 0;

    // One memory-mode cycle: respond, accept a request, pop, then check.
    task automatic mem_cycle(input int rdy_pct, input int rsp_pct, input int pop_pct,
                             input logic [15:0] b);
        int exp_lvl;
        bit pacc;
        @(negedge clk);
        cyc++;
        if (drove_rsp) rsp_done++;
        drove_rsp = 0;
        mem_rsp_valid = 0;
        if (paddr.size() > 0 && pcyc[0] < cyc && ($urandom % 100) < rsp_pct) begin
            mem_rsp_valid = 1;
            mem_rsp_data  = word_at(paddr.pop_front());
            void'(pcyc.pop_front());
            drove_rsp = 1;
        end
        mem_req_ready = ($urandom % 100) < rdy_pct;
        pop_req = ($urandom % 100) < pop_pct;
        push_valid = 0;
        #1;
        exp_lvl = rsp_done / 4 - popped;
        chk(level == 4'(exp_lvl), "R9", 64'(level), 64'(exp_lvl));
        chk(done == (popped == NREQ_RUN), "R10", 64'(done), 64'(popped == NREQ_RUN));
        if (mem_req_valid && mem_req_ready) begin
            chk(mem_req_addr == b + 16'(nreq), "R7", 64'(mem_req_addr), 64'(b + 16'(nreq)));
            paddr.push_back(mem_req_addr);
            pcyc.push_back(cyc);
            nreq++;
        end
        pacc = pop_req && !pop_stall;
        chk(pop_stall == (pop_req && exp_lvl == 0), "R4", 64'(pop_stall), 64'(pop_req && exp_lvl == 0));
        if (pacc) begin
            chk(pop_data == elem_at(b, popped), "R8", pop_data, elem_at(b, popped));
            popped++;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] b;
        void'($urandom(32'd2024));
        rst_n = 0; mode_link = 1; base_addr = 0; elem_count = 0; idle_inputs();

        // Reset state, link mode.
        do_reset(1'b1);
        @(negedge clk); pop_req = 1; peek_req = 1; #1;
        chk(level == 0, "R2", 64'(level), 0);
        chk(pop_stall == 1, "R4", 64'(pop_stall), 1);
        chk(peek_stall == 1 && peek_valid == 0, "R4", {peek_stall, peek_valid}, 64'b10);
        chk(mem_req_valid == 0 && done == 0, "R10", {mem_req_valid, done}, 0);
        pop_req = 0; peek_req = 0;

        // Link mode: fill-heavy, drain-heavy, balanced.
        link_stretch(150, 85, 15);
        link_stretch(150, 15, 85);
        link_stretch(400, 60, 55);

        // Memory mode: push ignored before a run.
        do_reset(1'b0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); push_valid = 1; push_data = {$urandom, $urandom}; #1;
            chk(push_busy == 0, "R11", 64'(push_busy), 0);
            chk(level == 0, "R11", 64'(level), 0);
        end
        push_valid = 0;

        // Start a run that wraps the address space.
        b = 16'hFFF6;
        @(negedge clk); base_addr = b; elem_count = 8'(NREQ_RUN); start = 1;
        @(negedge clk); start = 0;
        cyc = 0; nreq = 0; rsp_done = 0; popped = 0; drove_rsp = 0;

        // Idle consumer, prompt memory: buffer fills, requests stop at the limit.
        for (int i = 0; i < 120; i++) mem_cycle(100, 100, 0, b);
        chk(nreq == DEPTH * 4, "R9", 64'(nreq), 64'(DEPTH * 4));
        chk(level == 4'(DEPTH), "R9", 64'(level), 64'(DEPTH));

        // Random ready, delay and pops until the run drains.
        for (int i = 0; i < 4000 && popped < NREQ_RUN; i++) mem_cycle(60, 60, 40, b);
        for (int i = 0; i < 10; i++) mem_cycle(100, 100, 50, b);
        chk(popped == NREQ_RUN, "R10", 64'(popped), 64'(NREQ_RUN));
        chk(nreq == NREQ_RUN * 4, "R7", 64'(nreq), 64'(NREQ_RUN * 4));
        chk(done == 1, "R10", 64'(done), 1);

        // Held request: with ready low the address must not move.
        begin
            logic [15:0] a0;
            do_reset(1'b0);
            @(negedge clk); base_addr = 16'h0100; elem_count = 8'd2; start = 1;
            @(negedge clk); start = 0; mem_req_ready = 0; #1;
            a0 = mem_req_addr;
            chk(mem_req_valid == 1 && a0 == 16'h0100, "R7", 64'(a0), 64'h0100);
            @(negedge clk); #1;
            chk(mem_req_valid == 1 && mem_req_addr == a0, "R12", 64'(mem_req_addr), 64'(a0));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule